// File: doc/BRIEF.md
# Reset-Gated Memory Chip-Enable

This block sits between a bus master's active-low memory chip-enable and the memory it selects. It keeps battery-backed memory from being written while the supervisor holds the system in reset. In normal operation the request passes straight through to the output as combinational logic. While the path is closed, the output is driven to its inactive high level.

When reset arrives during an access, the path does not cut off at once. An access already under way may finish: the output keeps following the low request until the request rises or a grace window of `GRACE_CYCLES` clock cycles runs out, whichever comes first. The reset input may come from a supply drop or from a watchdog fault; the block handles both the same way.

After power-up, or after any reset, the path stays closed until reset is released. It then reopens only after the request has been seen high, so a partial access never reaches the memory. The battery-backup flag closes the path at once, in every state.

Top module: `ce_gate`

## Requirements
- R1: While `rstN` is low, `ceGatedN` is 1. After `rstN` is released, the path stays closed until the R8 condition is met.
- R2: With the path open, `rstActive` low and `onBattery` low, `ceGatedN` equals `ceReqN` in the same cycle, with no register in between.
- R3: If `rstActive` is sampled high while the path is open and `ceReqN` is low, `ceGatedN` stays low in that cycle and for `GRACE_CYCLES` more cycles as long as the request stays low. It is 1 in the cycle after that.
- R4: If `ceReqN` goes high during the grace window, `ceGatedN` goes high in the same cycle and the path closes.
- R5: Once the grace window has ended, `ceGatedN` stays 1 for as long as `rstActive` stays high, even if `ceReqN` goes low again.
- R6: If `rstActive` is sampled high while `ceReqN` is high, the path closes at that edge. A later low request during reset is not passed.
- R7: While `onBattery` is 1, `ceGatedN` is 1 in every state, and the path is closed from the next edge on.
- R8: With the path closed, it reopens only at a clock edge where `rstActive` is low, `onBattery` is low and `ceReqN` is high. A request held low across the release of reset never reaches the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; it also times the grace window |
| rstN | input | 1 | Active-low asynchronous reset of the gate state |
| ceReqN | input | 1 | Chip-enable request from the bus master, active low |
| rstActive | input | 1 | Reset-active level from the supervisor, covering both supply and watchdog causes |
| onBattery | input | 1 | Battery-backup mode flag |
| ceGatedN | output | 1 | Gated chip-enable to the memory, active low |

## Verification
The bench builds the gate with `GRACE_CYCLES` set to 6. With that value, the full grace window and the cycle in which it expires can be checked within a handful of cycles, next to an access cut short by a rising request. The same value lets the bench cover battery entry both in the open state and in the middle of a grace window. It also covers reopening after reset with the request held low and then released.

// File: rtl/cegate_pkg.sv
package cegate_pkg;

  typedef enum logic [1:0] {
    GS_BLOCKED = 2'd0,
    GS_OPEN    = 2'd1,
    GS_GRACE   = 2'd2
  } gateState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic graceLoad;   // restart the grace counter
    logic graceStep;   // advance the grace counter
    logic pathOpen;    // let the request through to the output
  } gateStrobe_t;

endpackage

// File: rtl/ce_gate_ctrl.sv
module ce_gate_ctrl
  import cegate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ceReqN,
  input  logic        rstActive,
  input  logic        onBattery,
  input  logic        graceLast,
  output gateStrobe_t strobe
);

  gateState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= GS_BLOCKED;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext        = state;
    strobe.graceLoad = 1'b0;
    strobe.graceStep = 1'b0;
    strobe.pathOpen  = !onBattery && (state != GS_BLOCKED);
    unique case (state)
      GS_OPEN: begin
        if (onBattery) begin
          stateNext = GS_BLOCKED;
        end else if (rstActive) begin
          if (!ceReqN) begin
            stateNext        = GS_GRACE;
            strobe.graceLoad = 1'b1;
          end else begin
            stateNext = GS_BLOCKED;
          end
        end
      end
      GS_GRACE: begin
        strobe.graceStep = 1'b1;
        if (onBattery || ceReqN || graceLast) stateNext = GS_BLOCKED;
      end
      GS_BLOCKED: begin
        if (!rstActive && !onBattery && ceReqN) stateNext = GS_OPEN;
      end
      default: stateNext = GS_BLOCKED;
    endcase
  end

endmodule

// File: rtl/ce_gate_dpath.sv
module ce_gate_dpath
  import cegate_pkg::*;
#(
  parameter int GRACE_CYCLES = 750
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ceReqN,
  input  gateStrobe_t strobe,
  output logic        graceLast,
  output logic        ceGatedN
);

  localparam int CW = (GRACE_CYCLES > 1) ? $clog2(GRACE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(GRACE_CYCLES - 1);

  logic [CW-1:0] graceCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 graceCnt <= '0;
    else if (strobe.graceLoad) graceCnt <= '0;
    else if (strobe.graceStep && graceCnt != LAST) graceCnt <= graceCnt + 1'b1;
  end

  assign graceLast = (graceCnt == LAST);
  assign ceGatedN  = strobe.pathOpen ? ceReqN : 1'b1;

endmodule

// File: rtl/ce_gate.sv
module ce_gate
  import cegate_pkg::*;
#(
  parameter int GRACE_CYCLES = 750
) (
  input  logic clk,
  input  logic rstN,
  input  logic ceReqN,
  input  logic rstActive,
  input  logic onBattery,
  output logic ceGatedN
);

  gateStrobe_t strobe;
  logic        graceLast;

  ce_gate_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ceReqN    (ceReqN),
    .rstActive (rstActive),
    .onBattery (onBattery),
    .graceLast (graceLast),
    .strobe    (strobe)
  );

  ce_gate_dpath #(.GRACE_CYCLES(GRACE_CYCLES)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ceReqN    (ceReqN),
    .strobe    (strobe),
    .graceLast (graceLast),
    .ceGatedN  (ceGatedN)
  );

endmodule

// File: rtl/ce_gate_checker.sv
module ce_gate_checker #(
  parameter int GRACE_CYCLES = 750
) (
  input logic clk,
  input logic rstN,
  input logic ceReqN,
  input logic rstActive,
  input logic onBattery,
  input logic ceGatedN
);

  localparam int LW = $clog2(GRACE_CYCLES + 2) + 1;

  // Consecutive sampled edges with reset active and the output low
  logic [LW-1:0] lowRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        lowRun <= '0;
    else if (rstActive && !ceGatedN)  lowRun <= lowRun + 1'b1;
    else                              lowRun <= '0;
  end

  always_comb begin
    if (!rstN) AST_RESET_CLOSED: assert (ceGatedN); // R1
  end

  AST_LOW_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !ceGatedN |-> !ceReqN); // R2

  AST_GRACE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (rstActive && !ceGatedN) |-> (lowRun <= LW'(GRACE_CYCLES))); // R3

  AST_STAYS_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    (rstActive && ceGatedN) ##1 rstActive |-> ceGatedN); // R5

  AST_BATTERY_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    onBattery |-> ceGatedN); // R7

  AST_REOPEN_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ceGatedN) |-> $past(ceReqN)); // R8

endmodule

bind ce_gate ce_gate_checker #(.GRACE_CYCLES(GRACE_CYCLES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .ceReqN    (ceReqN),
  .rstActive (rstActive),
  .onBattery (onBattery),
  .ceGatedN  (ceGatedN)
);

// File: tb/ce_gate_tb.sv
module ce_gate_tb;

  localparam int CLK_PERIOD = 10;
  localparam int GRACE      = 6;

  typedef struct {
    logic  expOut;
    string tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceReqN = 1'b1;
  logic rstActive = 1'b1;
  logic onBattery = 1'b0;
  logic ceGatedN;

  int vecCount = 0;
  int failCount = 0;
  bit finished = 1'b0;
  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ce_gate #(.GRACE_CYCLES(GRACE)) u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .ceReqN    (ceReqN),
    .rstActive (rstActive),
    .onBattery (onBattery),
    .ceGatedN  (ceGatedN)
  );

  // Driver: apply one cycle of inputs and queue the expected output
  task automatic step(input logic rn, input logic req, input logic ra,
                      input logic bat, input logic exp, input string tag);
    expItem_t it;
    @(negedge clk);
    rstN = rn; ceReqN = req; rstActive = ra; onBattery = bat;
    it.expOut = exp;
    it.tag    = tag;
    expQ.push_back(it);
  endtask

  // Monitor: compare just before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/2 - 1);
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        vecCount++;
        if (ceGatedN !== it.expOut) begin
          failCount++;
          $display("FAIL %s: ceGatedN=%b expected %b at %0t",
                   it.tag, ceGatedN, it.expOut, $time);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end

  initial begin
    // R1: held in reset, request low
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 1, "R1");
    step(1, 0, 1, 0, 1, "R1");
    // R8: reset released, request still low: stays closed
    step(1, 0, 0, 0, 1, "R8");
    step(1, 0, 0, 0, 1, "R8");
    step(1, 1, 0, 0, 1, "R8");
    // R2: open pass-through
    step(1, 0, 0, 0, 0, "R2");
    step(1, 1, 0, 0, 1, "R2");
    step(1, 0, 0, 0, 0, "R2");
    // R3: full grace window
    for (int i = 0; i <= GRACE; i++) step(1, 0, 1, 0, 0, "R3");
    step(1, 0, 1, 0, 1, "R3");
    step(1, 1, 1, 0, 1, "R5");
    step(1, 0, 1, 0, 1, "R5");
    step(1, 0, 0, 0, 1, "R8");
    step(1, 1, 0, 0, 1, "R8");
    step(1, 0, 0, 0, 0, "R2");
    // R4: request rises inside the grace window
    step(1, 0, 1, 0, 0, "R3");
    step(1, 0, 1, 0, 0, "R3");
    step(1, 1, 1, 0, 1, "R4");
    step(1, 0, 1, 0, 1, "R4");
    step(1, 1, 0, 0, 1, "R8");
    step(1, 0, 0, 0, 0, "R2");
    step(1, 1, 0, 0, 1, "R2");
    // R6: reset arrives with request high
    step(1, 1, 1, 0, 1, "R6");
    step(1, 0, 1, 0, 1, "R6");
    step(1, 1, 0, 0, 1, "R8");
    step(1, 0, 0, 0, 0, "R2");
    // R7: battery while open
    step(1, 0, 0, 1, 1, "R7");
    step(1, 0, 0, 0, 1, "R7");
    step(1, 1, 0, 0, 1, "R8");
    step(1, 0, 0, 0, 0, "R2");
    // R7: battery inside a grace window
    step(1, 0, 1, 0, 0, "R3");
    step(1, 0, 1, 1, 1, "R7");
    step(1, 0, 1, 0, 1, "R7");
    step(1, 1, 0, 0, 1, "R8");
    step(1, 0, 0, 0, 0, "R2");
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

endmodule